// File: doc/BRIEF.md
# PHY Configuration Test-Port Register Programmer

This block is the PHY-side end of a slow, host-driven serial programming port. A host toggles a programming clock, an enable line and an 8-bit data bus; the block turns those level changes into register accesses on a file of 8-bit configuration registers, each addressed by an 8-bit register code. A falling edge of the programming clock with the enable high captures the bus as the current register code. A rising edge with the enable low stores the bus into the register that code names. The data-out bus always shows the register at the current code, so the host can read back what it wrote.

The PLL divider settings are not applied directly. The loop divider value M-1 (9 bits) is written to code 0x18 in two halves, chosen by bit 7 of the written byte. The input divider value N-1 (7 bits) is written to code 0x17. Both are only staged by these writes. They reach the effective divider outputs only when the commit register at code 0x19 is written with its loop-commit bit (bit 5) or input-commit bit (bit 4) set. The host is expected to commit the low half before it writes the high half. The programming clock is an ordinary input sampled by the system clock, and its edges are found by comparing it with its value one cycle earlier.

Top module: `phy_cfg_port`

## Requirements
- R1: After the synchronous active-high `rst`, every register, the current code, the staged divider values and both divider outputs are zero, so `prg_dout`, `loop_div_m1` and `in_div_n1` read 0.
- R2: A falling edge of `prg_clk` while `prg_en` is high makes `prg_din` the current register code and changes no register contents.
- R3: A rising edge of `prg_clk` while `prg_en` is low stores `prg_din` into the register selected by the current code.
- R4: A rising edge of `prg_clk` while `prg_en` is high stores nothing, and a falling edge while `prg_en` is low leaves the current code unchanged.
- R5: `prg_dout` equals the stored contents of the register at the current code at all times, for every one of the 256 codes.
- R6: A write to code 0x18 with bit 7 clear stages bits [4:0] as bits [4:0] of M-1; with bit 7 set it stages bits [3:0] as bits [8:5] of M-1. Neither changes `loop_div_m1`.
- R7: A write to code 0x19 with bit 5 set loads the staged M-1 into `loop_div_m1`. With bit 4 set it loads bits [6:0] of the last value written to code 0x17 into `in_div_n1`. An output whose commit bit is clear keeps its value.
- R8: `prg_clr` high at a system clock edge clears every register, the current code, the staged values and both divider outputs to zero.
- R9: Each level change of `prg_clk` acts once. A level held for many system clock cycles causes no further register access, even if `prg_din` changes meanwhile.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| prg_clk | input | 1 | Host-driven programming clock, sampled as data |
| prg_en | input | 1 | High: falling edge captures a code; low: rising edge writes data |
| prg_clr | input | 1 | Synchronous clear of all programmed state |
| prg_din | input | 8 | Register code or write data from the host |
| prg_dout | output | 8 | Contents of the register at the current code |
| loop_div_m1 | output | 9 | Effective loop divider value M-1 |
| in_div_n1 | output | 7 | Effective input divider value N-1 |

## Verification
The assertions assume that `prg_clk` holds each level for at least one system clock cycle. If it does not, edges are lost rather than mis-decoded. They also assume that `prg_en` and `prg_din` are steady in the cycle where the edge is seen. The bench changes every input only on the falling edge of `clk`, and it holds each programming-clock level for at least two system cycles. It also sets up the code or data before it moves `prg_clk`, so each access is taken from settled inputs.

// File: rtl/phy_cfg_pkg.sv
package phy_cfg_pkg;

    localparam int CODE_W = 8;
    localparam int DATA_W = 8;

    // codes whose writes feed the divider staging logic
    localparam logic [7:0] CODE_IN_DIV   = 8'h17;
    localparam logic [7:0] CODE_LOOP_DIV = 8'h18;
    localparam logic [7:0] CODE_DIV_CMT  = 8'h19;

    // bit positions inside the written byte
    localparam int HALF_SEL_BIT   = 7;
    localparam int LOOP_CMT_BIT   = 5;
    localparam int IN_CMT_BIT     = 4;

    localparam int LO_W = 5;
    localparam int HI_W = 4;
    localparam int M_W  = LO_W + HI_W;
    localparam int N_W  = 7;

    typedef struct packed {
        logic rise;
        logic fall;
    } prg_edge_t;

    typedef struct packed {
        logic [HI_W-1:0] hi;
        logic [LO_W-1:0] lo;
    } loop_div_t;

    function automatic logic hits(input logic [7:0] code, input logic [7:0] target);
        return code == target;
    endfunction

endpackage

// File: rtl/prg_edge_detect.sv
module prg_edge_detect
    import phy_cfg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      prg_clk,
    output prg_edge_t ev
);

    logic prg_clk_q;

    always_ff @(posedge clk) begin
        if (rst) prg_clk_q <= 1'b0;
        else     prg_clk_q <= prg_clk;
    end

    always_comb begin
        ev.rise = prg_clk & ~prg_clk_q;
        ev.fall = ~prg_clk & prg_clk_q;
    end

    // R9: a held level never reports a second rising event
    p_single_rise_r9: assert property (@(posedge clk) disable iff (rst)
        ev.rise |=> !ev.rise);

    // R9: a held level never reports a second falling event
    p_single_fall_r9: assert property (@(posedge clk) disable iff (rst)
        ev.fall |=> !ev.fall);

endmodule

// File: rtl/prg_regfile.sv
module prg_regfile
    import phy_cfg_pkg::*;
#(
    parameter int AW = CODE_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    localparam int NREG = 1 << AW;

    logic [DW-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (wr_en) begin
            regs[wr_addr] <= wr_data;
        end
    end

    assign rd_data = regs[rd_addr];

    // R3: an accepted write is visible at its address one cycle later
    p_write_lands_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !clr) |=> regs[$past(wr_addr)] == $past(wr_data));

endmodule

// File: rtl/prg_div_stage.sv
module prg_div_stage
    import phy_cfg_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           clr,
    input  logic           wr_en,
    input  logic [7:0]     wr_code,
    input  logic [7:0]     wr_data,
    output logic [M_W-1:0] loop_div_m1,
    output logic [N_W-1:0] in_div_n1
);

    loop_div_t      staged_loop;
    loop_div_t      eff_loop;
    logic [N_W-1:0] staged_in;
    logic [N_W-1:0] eff_in;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            staged_loop <= '0;
            eff_loop    <= '0;
            staged_in   <= '0;
            eff_in      <= '0;
        end else if (wr_en) begin
            if (hits(wr_code, CODE_IN_DIV))
                staged_in <= wr_data[N_W-1:0];
            if (hits(wr_code, CODE_LOOP_DIV)) begin
                if (wr_data[HALF_SEL_BIT]) staged_loop.hi <= wr_data[HI_W-1:0];
                else                       staged_loop.lo <= wr_data[LO_W-1:0];
            end
            if (hits(wr_code, CODE_DIV_CMT)) begin
                if (wr_data[LOOP_CMT_BIT]) eff_loop <= staged_loop;
                if (wr_data[IN_CMT_BIT])   eff_in   <= staged_in;
            end
        end
    end

    assign loop_div_m1 = eff_loop;
    assign in_div_n1   = eff_in;

    // R6: the loop divider output moves only on a commit with bit 5 or a clear
    p_loop_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!clr && !(wr_en && wr_code == CODE_DIV_CMT && wr_data[LOOP_CMT_BIT]))
        |=> $stable(loop_div_m1));

    // R7: the input divider output moves only on a commit with bit 4 or a clear
    p_in_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!clr && !(wr_en && wr_code == CODE_DIV_CMT && wr_data[IN_CMT_BIT]))
        |=> $stable(in_div_n1));

    // R8: clear leaves both divider outputs at zero
    p_clr_zero_r8: assert property (@(posedge clk) disable iff (rst)
        clr |=> (loop_div_m1 == '0 && in_div_n1 == '0));

endmodule

// File: rtl/phy_cfg_port.sv
module phy_cfg_port
    import phy_cfg_pkg::*;
#(
    parameter int AW = CODE_W,
    parameter int DW = DATA_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           prg_clk,
    input  logic           prg_en,
    input  logic           prg_clr,
    input  logic [7:0]     prg_din,
    output logic [7:0]     prg_dout,
    output logic [M_W-1:0] loop_div_m1,
    output logic [N_W-1:0] in_div_n1
);

    prg_edge_t     ev;
    logic [AW-1:0] code_q;
    logic          wr_en;

    prg_edge_detect u_edge (
        .clk     (clk),
        .rst     (rst),
        .prg_clk (prg_clk),
        .ev      (ev)
    );

    // code capture: falling programming-clock edge with enable high
    always_ff @(posedge clk) begin
        if (rst || prg_clr)        code_q <= '0;
        else if (ev.fall && prg_en) code_q <= prg_din[AW-1:0];
    end

    assign wr_en = ev.rise && !prg_en && !prg_clr;

    prg_regfile #(.AW(AW), .DW(DW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .clr     (prg_clr),
        .wr_en   (wr_en),
        .wr_addr (code_q),
        .wr_data (prg_din[DW-1:0]),
        .rd_addr (code_q),
        .rd_data (prg_dout)
    );

    prg_div_stage u_div (
        .clk         (clk),
        .rst         (rst),
        .clr         (prg_clr),
        .wr_en       (wr_en),
        .wr_code     (code_q),
        .wr_data     (prg_din),
        .loop_div_m1 (loop_div_m1),
        .in_div_n1   (in_div_n1)
    );

    // R2: the current code changes only on a falling edge with enable high
    p_code_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!prg_clr && !(ev.fall && prg_en)) |=> $stable(code_q));

    // R4: a rising edge with enable high disturbs neither code nor read data
    p_no_write_en_r4: assert property (@(posedge clk) disable iff (rst)
        (ev.rise && prg_en && !prg_clr) |=> $stable(prg_dout));

endmodule

// File: tb/phy_cfg_port_test.sv
module phy_cfg_port_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       prg_clk = 1'b0;
    logic       prg_en = 1'b0;
    logic       prg_clr = 1'b0;
    logic [7:0] prg_din = 8'h00;
    logic [7:0] prg_dout;
    logic [8:0] loop_div_m1;
    logic [6:0] in_div_n1;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phy_cfg_port uut (
        .clk         (clk),
        .rst         (rst),
        .prg_clk     (prg_clk),
        .prg_en      (prg_en),
        .prg_clr     (prg_clr),
        .prg_din     (prg_din),
        .prg_dout    (prg_dout),
        .loop_div_m1 (loop_div_m1),
        .in_div_n1   (in_div_n1)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic latch_code(input logic [7:0] c);
        prg_en  = 1'b1;
        prg_din = c;
        prg_clk = 1'b1;
        tick(2);
        prg_clk = 1'b0;
        tick(2);
        prg_en  = 1'b0;
    endtask

    task automatic write_reg(input logic [7:0] c, input logic [7:0] d);
        latch_code(c);
        prg_din = d;
        tick(1);
        prg_clk = 1'b1;
        tick(2);
    endtask

    function automatic logic [7:0] pat(input int c);
        return 8'((c * 37 + 11) ^ (c >> 3));
    endfunction

    // bench model of divider staging
    logic [4:0] st_lo;
    logic [3:0] st_hi;
    logic [6:0] st_n;
    logic [8:0] ex_m;
    logic [6:0] ex_n;

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog R1..R9 actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        // R1: reset state
        check("R1 dout after reset", prg_dout, 0);
        check("R1 loop divider after reset", loop_div_m1, 0);
        check("R1 input divider after reset", in_div_n1, 0);

        // R3 and R5: write every code, then read every code back
        for (int c = 0; c < 256; c++) begin
            write_reg(8'(c), pat(c));
            check("R3 written value at code", prg_dout, pat(c));
        end
        for (int c = 255; c >= 0; c--) begin
            latch_code(8'(c));
            check("R5 readback at code", prg_dout, pat(c));
        end

        // R2: a code capture alone changes no contents
        latch_code(8'h20);
        check("R2 capture leaves contents", prg_dout, pat(8'h20));

        // R4: rising edge with enable high, falling edge with enable low
        prg_en = 1'b1; prg_din = 8'hAA; tick(1);
        prg_clk = 1'b1; tick(3);
        check("R4 no write with enable high", prg_dout, pat(8'h20));
        prg_en = 1'b0; prg_din = 8'h55; tick(1);
        prg_clk = 1'b0; tick(3);
        check("R4 code kept on fall with enable low", prg_dout, pat(8'h20));
        latch_code(8'h55);
        check("R4 code 0x55 untouched", prg_dout, pat(8'h55));

        // R9: held high level after a write gives no second write
        write_reg(8'h33, 8'h5C);
        prg_din = 8'hE1;
        tick(6);
        check("R9 held level no rewrite", prg_dout, 8'h5C);

        // R8: clear wipes everything
        prg_clr = 1'b1; tick(1);
        prg_clr = 1'b0; tick(1);
        check("R8 dout after clear", prg_dout, 0);
        check("R8 loop divider after clear", loop_div_m1, 0);
        check("R8 input divider after clear", in_div_n1, 0);
        latch_code(8'h33);
        check("R8 register 0x33 cleared", prg_dout, 0);

        // R6 and R7: divider staging and commit sweep
        st_lo = '0; st_hi = '0; st_n = '0; ex_m = '0; ex_n = '0;
        for (int it = 0; it < 14; it++) begin
            int m1;
            int n1;
            m1 = (it == 13) ? 511 : it * 41;
            n1 = (m1 * 3 + it) & 127;

            write_reg(8'h17, 8'(n1));
            st_n = 7'(n1);
            check("R7 input divider staged only", in_div_n1, ex_n);

            write_reg(8'h18, 8'(m1 & 31));
            st_lo = 5'(m1 & 31);
            check("R6 low half staged only", loop_div_m1, ex_m);
            check("R5 code 0x18 raw readback", prg_dout, m1 & 31);

            write_reg(8'h19, 8'h30);
            ex_m = {st_hi, st_lo}; ex_n = st_n;
            check("R7 low commit loop divider", loop_div_m1, ex_m);
            check("R7 commit input divider", in_div_n1, ex_n);

            write_reg(8'h18, 8'(8'h80 | (m1 >> 5)));
            st_hi = 4'(m1 >> 5);
            check("R6 high half staged only", loop_div_m1, ex_m);

            write_reg(8'h19, 8'h00);
            check("R7 no commit bits loop", loop_div_m1, ex_m);

            write_reg(8'h17, 8'(n1 ^ 8'h5A));
            st_n = 7'(n1 ^ 8'h5A);
            if (it[0]) begin
                write_reg(8'h19, 8'h20);
                ex_m = {st_hi, st_lo};
            end else begin
                write_reg(8'h19, 8'h10);
                ex_n = st_n;
            end
            check("R7 partial commit loop", loop_div_m1, ex_m);
            check("R7 partial commit input", in_div_n1, ex_n);

            write_reg(8'h19, 8'h30);
            ex_m = {st_hi, st_lo}; ex_n = st_n;
            check("R7 full M-1 after high commit", loop_div_m1, m1);
            check("R7 final input divider", in_div_n1, ex_n);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule